// File: doc/BRIEF.md
# Circular Event Queue Writer

This block appends 32-bit event words to a circular queue that lives in system memory. For each request it takes a descriptor snapshot: the queue base address, a size code, the current slot index and the current generation bit. It issues one 4-byte write to the selected slot and then reports the slot index and generation bit for the next request. The caller writes these values back into its descriptor.

Every stored word carries the generation bit in its top bit. The bit inverts each time the index wraps to slot zero. A consumer polling the queue can therefore tell fresh entries from stale ones without a shared tail pointer. If the memory write fails, the descriptor state is reported back unchanged, so the same slot is used again on the next attempt.

Top module: `evq_writer`

## Requirements
- R1: The queue holds 2^(k+10) slots, where k is `cfg_size`. A size code above `MAX_SIZE_CODE` is treated as `MAX_SIZE_CODE`. The incoming `cfg_index` is reduced modulo the slot count before use.
- R2: The write address is `cfg_base + 4 * index`, with the reduced index from R1.
- R3: The stored word has the generation bit at bit 31 and event data bits 30:0 in bits 30:0. Event data bit 31 is discarded. The bus is big-endian: the byte at address `mem_addr + k` is carried on `mem_wdata[8k+7:8k]`, so lane 0 holds word bits 31:24.
- R4: After a successful write, `out_index` is the reduced index plus one, modulo the slot count.
- R5: When the new index is zero, `out_gen` is the inverse of `cfg_gen`, `out_flip_we` is 1 and `out_flip` equals the new `out_gen`. In every other case `out_gen` equals `cfg_gen` and `out_flip_we` is 0.
- R6: If the response has `mem_rsp_err` set, then `done_err` is 1, `out_index` equals the reduced index, `out_gen` equals `cfg_gen` and `out_flip_we` is 0.
- R7: The block handles one request at a time. `req_ready` is low from acceptance until the memory response has arrived. `mem_valid`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ready` is sampled high. `req_ready` and `mem_valid` are never high together.
- R8: `done` is a one-cycle pulse in the cycle after the one in which `mem_rsp_valid` is sampled. The `out_*` signals and `done_err` are valid in that cycle.
- R9: After reset, `req_ready` is 1 and `mem_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Append request |
| req_ready | output | 1 | Block can accept a request |
| req_data | input | 32 | Event data (bit 31 unused) |
| cfg_base | input | ADDR_W | Queue base byte address |
| cfg_size | input | SZ_W | Size code k, slot count 2^(k+10) |
| cfg_index | input | IDX_W | Current slot index |
| cfg_gen | input | 1 | Current generation bit |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_rsp_valid | input | 1 | Write response |
| mem_rsp_err | input | 1 | Response carries an error |
| done | output | 1 | Result pulse |
| done_err | output | 1 | The write failed |
| out_index | output | IDX_W | Index to write back |
| out_gen | output | 1 | Generation bit to write back |
| out_flip_we | output | 1 | A wrap occurred; update the flipped status |
| out_flip | output | 1 | Value for the flipped status |

## Verification
The memory request becomes visible one cycle after the request is accepted. It then stays unchanged through any number of cycles with `mem_ready` low, and the bench compares it at every falling edge during that time. The result pulse is due exactly one cycle after the response edge. The bench samples `done` and the four result outputs at the falling edge that follows that response edge. At every other falling edge it checks that `done` is low. Ready and response delays are varied between requests, so neither timing is checked only at a fixed latency.

// File: rtl/evq_pkg.sv
package evq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } evq_state_t;

    // Queue word: generation bit on top, event payload below.
    function automatic logic [31:0] evq_form_word(input logic gen, input logic [31:0] data);
        return {gen, data[30:0]};
    endfunction

    // Big-endian lane order: lane 0 (lowest address) carries bits 31:24.
    function automatic logic [31:0] evq_to_lanes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/evq_slot.sv
module evq_slot #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 3,
    parameter int IDX_W  = 14
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_eff,
    input  logic [IDX_W-1:0]  index_raw,
    input  logic              gen,
    input  logic [31:0]       data,
    output logic [IDX_W-1:0]  slot_mask,
    output logic [IDX_W-1:0]  index_red,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       lanes
);
    import evq_pkg::*;

    localparam int LOG_MIN = 10;

    for (genvar b = 0; b < IDX_W; b++) begin : g_mask
        assign slot_mask[b] = (32'(size_eff) + 32'(LOG_MIN)) > 32'(b);
    end

    assign index_red = index_raw & slot_mask;
    assign addr      = base + ADDR_W'({index_red, 2'b00});
    assign lanes     = evq_to_lanes(evq_form_word(gen, data));

endmodule

// File: rtl/evq_advance.sv
module evq_advance #(
    parameter int IDX_W = 14
) (
    input  logic [IDX_W-1:0] index_red,
    input  logic [IDX_W-1:0] slot_mask,
    input  logic             gen,
    output logic [IDX_W-1:0] next_index,
    output logic             next_gen,
    output logic             wrapped
);
    logic [IDX_W-1:0] bumped;

    assign bumped     = index_red + IDX_W'(1);
    assign next_index = bumped & slot_mask;
    assign wrapped    = (next_index == '0);
    assign next_gen   = gen ^ wrapped;

endmodule

// File: rtl/evq_writer.sv
module evq_writer #(
    parameter int ADDR_W        = 32,
    parameter int SZ_W          = 3,
    parameter int MAX_SIZE_CODE = 4,
    localparam int IDX_W        = MAX_SIZE_CODE + 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_data,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic              cfg_gen,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic              done,
    output logic              done_err,
    output logic [IDX_W-1:0]  out_index,
    output logic              out_gen,
    output logic              out_flip_we,
    output logic              out_flip
);
    import evq_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SZ_W-1:0]   size;
        logic [IDX_W-1:0]  index;
        logic              gen;
        logic [31:0]       data;
    } evq_req_t;

    evq_state_t       state_q;
    evq_req_t         req_q;
    logic [SZ_W-1:0]  size_clamped;
    logic [IDX_W-1:0] slot_mask, index_red, next_index;
    logic             next_gen, wrapped;

    assign size_clamped = (32'(cfg_size) > MAX_SIZE_CODE) ? SZ_W'(MAX_SIZE_CODE) : cfg_size;

    evq_slot #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_slot (
        .base      (req_q.base),
        .size_eff  (req_q.size),
        .index_raw (req_q.index),
        .gen       (req_q.gen),
        .data      (req_q.data),
        .slot_mask (slot_mask),
        .index_red (index_red),
        .addr      (mem_addr),
        .lanes     (mem_wdata)
    );

    evq_advance #(.IDX_W(IDX_W)) u_adv (
        .index_red  (index_red),
        .slot_mask  (slot_mask),
        .gen        (req_q.gen),
        .next_index (next_index),
        .next_gen   (next_gen),
        .wrapped    (wrapped)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign mem_valid = (state_q == ST_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            req_q       <= '0;
            done        <= 1'b0;
            done_err    <= 1'b0;
            out_index   <= '0;
            out_gen     <= 1'b0;
            out_flip_we <= 1'b0;
            out_flip    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.base  <= cfg_base;
                        req_q.size  <= size_clamped;
                        req_q.index <= cfg_index;
                        req_q.gen   <= cfg_gen;
                        req_q.data  <= req_data;
                        state_q     <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (mem_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        state_q  <= ST_IDLE;
                        done     <= 1'b1;
                        done_err <= mem_rsp_err;
                        if (mem_rsp_err) begin
                            out_index   <= index_red;
                            out_gen     <= req_q.gen;
                            out_flip_we <= 1'b0;
                            out_flip    <= req_q.gen;
                        end else begin
                            out_index   <= next_index;
                            out_gen     <= next_gen;
                            out_flip_we <= wrapped;
                            out_flip    <= next_gen;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk #(
    parameter int IDX_W  = 14,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic              done_err,
    input logic [IDX_W-1:0]  out_index,
    input logic              out_gen,
    input logic              out_flip_we,
    input logic              out_flip
);
    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

    assert_one_at_a_time_R7: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && mem_valid));

    assert_done_after_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_rsp_valid));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (rst)
        done && out_flip_we |-> (out_index == '0) && (out_flip == out_gen));

    assert_err_no_flip_R6: assert property (@(posedge clk) disable iff (rst)
        done && done_err |-> !out_flip_we);
endmodule

bind evq_writer evq_writer_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .done_err      (done_err),
    .out_index     (out_index),
    .out_gen       (out_gen),
    .out_flip_we   (out_flip_we),
    .out_flip      (out_flip)
);

// File: tb/test_evq_writer.sv
module test_evq_writer;
    localparam int ADDR_W = 32;
    localparam int SZ_W   = 3;
    localparam int MAXSZ  = 4;
    localparam int IDX_W  = MAXSZ + 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [31:0] req_data = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [SZ_W-1:0] cfg_size = '0;
    logic [IDX_W-1:0] cfg_index = '0;
    logic cfg_gen = 1'b0;
    logic mem_valid, mem_ready = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic done, done_err, out_gen, out_flip_we, out_flip;
    logic [IDX_W-1:0] out_index;

    always #4 clk = ~clk;

    evq_writer #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .MAX_SIZE_CODE(MAXSZ)) i_evq_writer (.*);

    int errs = 0, checks = 0;
    bit finished = 0;

    // Reference state
    bit        exp_mem_on = 0;
    bit        exp_done_now = 0;
    longint    e_addr;
    bit [31:0] e_lanes;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the memory port and stray result pulses.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(mem_valid == exp_mem_on, "R7 mem_valid", mem_valid, exp_mem_on);
            if (exp_mem_on) begin
                chk(mem_addr == e_addr[ADDR_W-1:0], "R2 address", mem_addr, e_addr);
                chk(mem_wdata == e_lanes, "R3 lanes", mem_wdata, e_lanes);
                chk(!req_ready, "R7 ready low while sending", req_ready, 0);
            end
            if (!exp_done_now) chk(!done, "R8 no stray done", done, 0);
        end
    end

    task automatic append(input longint base, input int sz, input int idx, input bit gen,
                          input bit [31:0] data, input bit err, input int rdy_dly, input int rsp_dly);
        int szc, n, ridx, nidx;
        bit wrap, ngen;
        bit [31:0] w;
        szc  = (sz > MAXSZ) ? MAXSZ : sz;
        n    = 1 << (szc + 10);
        ridx = idx % n;
        nidx = (ridx + 1) % n;
        wrap = (nidx == 0);
        ngen = gen ^ wrap;
        w    = {gen, data[30:0]};
        e_addr  = base + 4 * ridx;
        e_lanes = {w[7:0], w[15:8], w[23:16], w[31:24]};
        @(negedge clk);
        chk(req_ready, "R7 ready before request", req_ready, 1);
        req_valid = 1; req_data = data; cfg_base = base[ADDR_W-1:0];
        cfg_size = SZ_W'(sz); cfg_index = IDX_W'(idx); cfg_gen = gen;
        @(posedge clk);
        exp_mem_on = 1;
        @(negedge clk);
        req_valid = 0; cfg_index = '0; cfg_gen = 0; req_data = '0;
        for (int i = 0; i < rdy_dly; i++) @(negedge clk);
        mem_ready = 1;
        @(posedge clk);
        exp_mem_on = 0;
        @(negedge clk);
        mem_ready = 0;
        chk(!req_ready, "R7 ready low awaiting response", req_ready, 0);
        for (int i = 0; i < rsp_dly; i++) @(negedge clk);
        mem_rsp_valid = 1; mem_rsp_err = err;
        @(posedge clk);
        exp_done_now = 1;
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_err = 0;
        chk(done, "R8 done pulse", done, 1);
        chk(done_err == err, "R6 done_err", done_err, err);
        if (err) begin
            chk(out_index == IDX_W'(ridx), "R6 index kept", out_index, ridx);
            chk(out_gen == gen, "R6 gen kept", out_gen, gen);
            chk(!out_flip_we, "R6 no flip", out_flip_we, 0);
        end else begin
            chk(out_index == IDX_W'(nidx), "R4 next index", out_index, nidx);
            chk(out_gen == ngen, "R5 gen", out_gen, ngen);
            chk(out_flip_we == wrap, "R5 flip write", out_flip_we, wrap);
            if (wrap) chk(out_flip == ngen, "R5 flip value", out_flip, ngen);
        end
        @(posedge clk);
        exp_done_now = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready, "R9 reset ready", req_ready, 1);
        chk(!mem_valid, "R9 reset mem_valid", mem_valid, 0);
        chk(!done, "R9 reset done", done, 0);
        append(64'h1000_0000, 0, 5, 0, 32'hDEAD_BEEF, 0, 0, 0);     // R3 bit31 dropped
        append(64'h1000_0000, 0, 1023, 0, 32'h0000_0011, 0, 2, 1);  // R5 wrap to gen 1
        append(64'h1000_0000, 0, 1023, 1, 32'h7FFF_FFFF, 0, 1, 3);  // R5 wrap to gen 0
        append(64'h2000_0040, 1, 10, 1, 32'h1234_5678, 1, 0, 2);    // R6 error
        append(64'h2000_0040, 0, 1023, 0, 32'h0000_0001, 1, 3, 0);  // R6 error at wrap slot
        append(64'h3000_0000, 2, 4095, 0, 32'hA5A5_5A5A, 0, 0, 0);  // R1 size 2 wrap
        append(64'h3000_0000, 2, 2047, 1, 32'h0102_0304, 0, 1, 1);  // R1 no wrap at 2047
        append(64'h4000_0000, 7, 16383, 1, 32'hCAFE_F00D, 0, 0, 1); // R1 clamp, wrap
        append(64'h4000_0000, 6, 2000, 0, 32'h0BAD_CAFE, 0, 2, 0);  // R1 clamp
        append(64'h5000_0000, 0, 1500, 0, 32'h8000_0000, 0, 0, 0);  // R1 index reduced
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errs++;
            $display("FAIL R8 watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule